// File: doc/BRIEF.md
# Peripheral Control Register Decoder

This block sits in front of a shared control region that holds ten groups of 32-bit peripheral registers. Every request carries a 32-bit address, a direction, an access size and write data. The group is chosen by comparing address bits 28 down to 16 with a table of group keys. The low eight address bits give the offset, and the offset divided by four selects the slot inside the group. Every group has its own offset limit for reads and another for writes. A request past the limit, or to an address that matches no group, returns zero and raises an error.

The behaviour of each slot comes from its attribute:

- **Storage:** the slot keeps what is written to it.
- **Constant:** the slot holds its reset value.
- **No-access:** the slot reads as zero and ignores writes.
- **External:** the access goes out as a one-cycle strobe to logic that lives outside this block.

Two extra keys mark write-only holes. Writes to them are taken without complaint, and reads return zero. The attribute map, the limits, the keys and the reset values are all parameters, fixed at elaboration.

Top module: `ctrl_reg_decoder`

## Requirements
- R1: The group is the index of the entry in the key table that equals `req_addr[28:16]`. The slot index is `req_addr[7:2]`. Address bits 31..29 and 15..8 have no effect.
- R2: Each group has a read limit and a write limit, and they can differ. A request to a known group whose offset `req_addr[7:0]` is greater than the limit for its direction is an error: a read returns 0 and a write changes nothing.
- R3: A request whose key matches no group and no hole key returns 0 and is dropped. It sets `rsp_err` in its response.
- R4: A request whose key equals either hole key raises no error. A write to a hole is discarded, and a read returns 0.
- R5: The size encoding is 0 = byte, 1 = halfword, 2 or 3 = word. A write to a storage slot replaces only the low 8, 16 or 32 bits. Every read returns the low 8, 16 or 32 bits with zeros above.
- R6: A constant slot keeps its reset value. A write to it is ignored and is not an error.
- R7: A no-access slot reads as 0, whatever its stored value. A write to it is ignored and is not an error.
- R8: An in-range request to an external slot behaves as follows:
  - In the request cycle it pulses `ext_rd_stb` or `ext_wr_stb`, and it drives the group, index, size and write data onto the `ext_*` outputs.
  - A read response carries `ext_rdata` as it stood in the request cycle, cut to the access size.
  - An external slot that is out of range produces no strobe.
- R9: Every request with `req_valid` high produces one response on the next clock edge, carrying `rsp_valid`, `rsp_err` and `rsp_rdata`. The data of a write response is 0.
- R10: An active-low reset restores every slot to `{TAG[group], 8'h00, 8'(slot)}` and clears the response outputs. Requests are accepted from the second clock edge after `rst_n` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 byte, 1 halfword, 2/3 word |
| req_addr | input | 32 | Request address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response of last cycle's request |
| rsp_err | output | 1 | Miss or range error |
| rsp_rdata | output | 32 | Read data, zero-extended |
| ext_rd_stb | output | 1 | Read strobe to an external slot handler |
| ext_wr_stb | output | 1 | Write strobe to an external slot handler |
| ext_grp | output | 4 | Group of the strobed slot |
| ext_idx | output | 6 | Index of the strobed slot |
| ext_size | output | 2 | Size of the strobed access |
| ext_wdata | output | 32 | Write data for the handler |
| ext_rdata | input | 32 | Handler read result, same cycle as the strobe |

## Verification
The range check and the external-slot routing both act on the same request in the same cycle. A slot can be external and yet lie between the write limit and the read limit of its group. The bench targets such a slot, at offset 0x40 of group 0, from both directions. A read there must strobe the handler and return its data with no error. A write there must leave both strobes low and come back as an error. This shows that the range check gates the strobe and that the strobe never hides the error.

// File: rtl/cdr_pkg.sv
package cdr_pkg;
  typedef enum logic [1:0] {AT_STORE = 2'd0, AT_CONST = 2'd1, AT_NOACC = 2'd2, AT_EXT = 2'd3} attr_e;

  localparam int DW  = 32;
  localparam int OFW = 8;
  localparam int IXW = OFW - 2;

  function automatic logic [DW-1:0] size_mask(input logic [1:0] sz);
    case (sz)
      2'd0:    size_mask = 32'h0000_00FF;
      2'd1:    size_mask = 32'h0000_FFFF;
      default: size_mask = 32'hFFFF_FFFF;
    endcase
  endfunction
endpackage

// File: rtl/cdr_decode.sv
module cdr_decode
  import cdr_pkg::*;
#(
  parameter int NG = 10,
  parameter int KW = 13,
  parameter logic [NG*KW-1:0]  KEYS   = '0,
  parameter logic [KW-1:0]     HOLE_A = '0,
  parameter logic [KW-1:0]     HOLE_B = '0,
  parameter logic [NG*OFW-1:0] RD_LIM = '0,
  parameter logic [NG*OFW-1:0] WR_LIM = '0,
  localparam int GW = (NG > 1) ? $clog2(NG) : 1
) (
  input  logic [31:0]    addr,
  input  logic           is_write,
  output logic [GW-1:0]  grp,
  output logic [IXW-1:0] idx,
  output logic           known,
  output logic           hole,
  output logic           in_range
);
  logic [KW-1:0]  key;
  logic [OFW-1:0] off;
  logic [OFW-1:0] lim;
  logic           unused_hi;

  assign key       = addr[16 +: KW];
  assign off       = addr[OFW-1:0];
  assign idx       = off[OFW-1:2];
  assign unused_hi = ^{addr[31:16+KW], addr[15:OFW], off[1:0]};

  always_comb begin
    known = 1'b0;
    grp   = '0;
    for (int g = 0; g < NG; g++) begin
      if (key == KEYS[g*KW +: KW]) begin
        known = 1'b1;
        grp   = GW'(g);
      end
    end
    hole     = !known && ((key == HOLE_A) || (key == HOLE_B));
    lim      = is_write ? WR_LIM[int'(grp)*OFW +: OFW] : RD_LIM[int'(grp)*OFW +: OFW];
    in_range = known && (off <= lim);
  end
endmodule

// File: rtl/cdr_slot_bank.sv
module cdr_slot_bank
  import cdr_pkg::*;
#(
  parameter int NG = 10,
  parameter int MS = 19,
  parameter logic [NG*MS-1:0] CONST_MAP = '0,
  parameter logic [NG*MS-1:0] NOACC_MAP = '0,
  parameter logic [NG*MS-1:0] EXT_MAP   = '0,
  parameter logic [NG*16-1:0] RST_TAG   = '0,
  localparam int GW = (NG > 1) ? $clog2(NG) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [GW-1:0]  grp,
  input  logic [IXW-1:0] idx,
  input  logic [1:0]     size,
  input  logic [DW-1:0]  wdata,
  output logic [DW-1:0]  rd_data,
  output attr_e          attr
);
  logic [DW-1:0] slot_view [NG*MS];
  attr_e         attr_view [NG*MS];
  logic [DW-1:0] wmask;

  assign wmask = size_mask(size);

  for (genvar g = 0; g < NG; g++) begin : g_grp
    for (genvar s = 0; s < MS; s++) begin : g_slot
      localparam int         FI = g*MS + s;
      localparam logic [31:0] RV = {RST_TAG[g*16 +: 16], 8'h00, 8'(s)};
      localparam attr_e      AT = NOACC_MAP[FI] ? AT_NOACC :
                                  CONST_MAP[FI] ? AT_CONST :
                                  EXT_MAP[FI]   ? AT_EXT   : AT_STORE;
      logic [DW-1:0] q, d;
      logic          we;

      always_comb begin
        we = wr_en && (AT == AT_STORE) && (grp == GW'(g)) && (idx == IXW'(s));
        d  = (q & ~wmask) | (wdata & wmask);
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  q <= RV;
        else if (we) q <= d;
      end

      assign slot_view[FI] = q;
      assign attr_view[FI] = AT;

      if (AT == AT_CONST) begin : g_const_chk
        // R6
        const_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) $stable(q));
      end
    end
  end

  always_comb begin
    rd_data = '0;
    attr    = AT_NOACC;
    if (int'(idx) < MS) begin
      rd_data = slot_view[int'(grp)*MS + int'(idx)];
      attr    = attr_view[int'(grp)*MS + int'(idx)];
    end
  end
endmodule

// File: rtl/ctrl_reg_decoder.sv
module ctrl_reg_decoder
  import cdr_pkg::*;
#(
  parameter int NG = 10,
  parameter int MS = 19,
  parameter int KW = 13,
  parameter logic [NG*KW-1:0] KEYS = {13'h1E09, 13'h1E08, 13'h1E07, 13'h1E06, 13'h1E05,
                                      13'h1E04, 13'h1E03, 13'h1E02, 13'h1E01, 13'h1E00},
  parameter logic [KW-1:0] HOLE_A = 13'h1E40,
  parameter logic [KW-1:0] HOLE_B = 13'h1E41,
  parameter logic [NG*OFW-1:0] RD_LIM = {8'h24, 8'h1C, 8'h3C, 8'h10, 8'h48,
                                         8'h20, 8'h40, 8'h2C, 8'h10, 8'h44},
  parameter logic [NG*OFW-1:0] WR_LIM = {8'h24, 8'h1C, 8'h3C, 8'h10, 8'h48,
                                         8'h20, 8'h40, 8'h2C, 8'h0C, 8'h3C},
  parameter logic [NG*MS-1:0] CONST_MAP = (NG*MS)'(1) << 20,
  parameter logic [NG*MS-1:0] NOACC_MAP = (NG*MS)'(1) << 2,
  parameter logic [NG*MS-1:0] EXT_MAP   = ((NG*MS)'(1) << 3) | ((NG*MS)'(1) << 16),
  parameter logic [NG*16-1:0] RST_TAG = {16'hA009, 16'hA008, 16'hA007, 16'hA006, 16'hA005,
                                         16'hA004, 16'hA003, 16'hA002, 16'hA001, 16'hA000},
  localparam int GW = (NG > 1) ? $clog2(NG) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [1:0]    req_size,
  input  logic [31:0]   req_addr,
  input  logic [31:0]   req_wdata,
  output logic          rsp_valid,
  output logic          rsp_err,
  output logic [31:0]   rsp_rdata,
  output logic          ext_rd_stb,
  output logic          ext_wr_stb,
  output logic [GW-1:0] ext_grp,
  output logic [5:0]    ext_idx,
  output logic [1:0]    ext_size,
  output logic [31:0]   ext_wdata,
  input  logic [31:0]   ext_rdata
);
  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync;
  logic       rst_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_ok = rst_sync[1];

  logic [GW-1:0]  grp;
  logic [IXW-1:0] idx;
  logic           known, hole, in_range;

  cdr_decode #(
    .NG(NG), .KW(KW), .KEYS(KEYS), .HOLE_A(HOLE_A), .HOLE_B(HOLE_B),
    .RD_LIM(RD_LIM), .WR_LIM(WR_LIM)
  ) u_decode (
    .addr(req_addr), .is_write(req_write), .grp(grp), .idx(idx),
    .known(known), .hole(hole), .in_range(in_range)
  );

  logic          act, bank_wr;
  logic [DW-1:0] bank_rd;
  attr_e         attr;

  assign act     = rst_ok && req_valid;
  assign bank_wr = act && req_write && in_range;

  cdr_slot_bank #(
    .NG(NG), .MS(MS), .CONST_MAP(CONST_MAP), .NOACC_MAP(NOACC_MAP),
    .EXT_MAP(EXT_MAP), .RST_TAG(RST_TAG)
  ) u_bank (
    .clk(clk), .rst_n(rst_ok), .wr_en(bank_wr), .grp(grp), .idx(idx),
    .size(req_size), .wdata(req_wdata), .rd_data(bank_rd), .attr(attr)
  );

  // external handler port, combinational in the request cycle
  logic ext_hit;
  assign ext_hit    = act && in_range && (attr == AT_EXT);
  assign ext_rd_stb = ext_hit && !req_write;
  assign ext_wr_stb = ext_hit && req_write;
  assign ext_grp    = grp;
  assign ext_idx    = idx;
  assign ext_size   = req_size;
  assign ext_wdata  = req_wdata;

  // response next-state
  logic          valid_d, err_d;
  logic [DW-1:0] rdata_d, sel_rd;

  always_comb begin
    case (attr)
      AT_STORE, AT_CONST: sel_rd = bank_rd;
      AT_EXT:             sel_rd = ext_rdata;
      default:            sel_rd = '0;
    endcase
    valid_d = act;
    err_d   = act && !in_range && !hole;
    rdata_d = '0;
    if (act && !req_write && in_range) rdata_d = sel_rd & size_mask(req_size);
  end

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= valid_d;
      rsp_err   <= err_d;
      rsp_rdata <= rdata_d;
    end
  end

  // R9
  rsp_follows_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    req_valid |=> rsp_valid);
  // R9
  wr_rsp_zero_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (req_valid && req_write) |=> (rsp_rdata == 32'h0));
  // R3
  err_data_zero_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    rsp_err |-> (rsp_rdata == 32'h0));
  // R4
  hole_no_err_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (req_valid && hole) |=> !rsp_err);
  // R8
  strobe_no_err_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (ext_rd_stb || ext_wr_stb) |=> !rsp_err);
  // R8
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    !(ext_rd_stb && ext_wr_stb));
  // R5
  byte_zext_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (req_valid && !req_write && req_size == 2'd0) |=> (rsp_rdata[31:8] == 24'h0));
endmodule

// File: tb/ctrl_reg_decoder_test.sv
module ctrl_reg_decoder_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [1:0]  req_size = 2'd2;
  logic [31:0] req_addr = '0, req_wdata = '0, ext_rdata = 32'hCAFE1234;
  logic        rsp_valid, rsp_err, ext_rd_stb, ext_wr_stb;
  logic [31:0] rsp_rdata, ext_wdata;
  logic [3:0]  ext_grp;
  logic [5:0]  ext_idx;
  logic [1:0]  ext_size;

  int checks = 0, fails = 0;
  logic        s_rd, s_wr, r_valid, r_err;
  logic [31:0] r_data, s_wdata;
  logic [3:0]  s_grp;
  logic [5:0]  s_idx;

  localparam logic [12:0] UNK = 13'h1E20, HA = 13'h1E40, HB = 13'h1E41;

  always #2.5 clk = ~clk;

  ctrl_reg_decoder uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .ext_rd_stb(ext_rd_stb), .ext_wr_stb(ext_wr_stb), .ext_grp(ext_grp),
    .ext_idx(ext_idx), .ext_size(ext_size), .ext_wdata(ext_wdata), .ext_rdata(ext_rdata)
  );

  function automatic logic [12:0] gk(input int g);
    return 13'h1E00 + 13'(g);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic acc(input logic w, input logic [1:0] sz, input logic [12:0] key,
                     input logic [7:0] off, input logic [31:0] wd, input logic [2:0] hi = 3'b101,
                     input logic [7:0] mid = 8'h5A);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_size = sz;
    req_addr = {hi, key, mid, off}; req_wdata = wd;
    #1;
    s_rd = ext_rd_stb; s_wr = ext_wr_stb; s_grp = ext_grp; s_idx = ext_idx; s_wdata = ext_wdata;
    @(negedge clk);
    req_valid = 1'b0;
    r_valid = rsp_valid; r_err = rsp_err; r_data = rsp_rdata;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset_state();
    chk("R10 rsp_valid idle", {31'h0, rsp_valid}, 32'h0);
    acc(0, 2, gk(2), 8'h14, 0);
    chk("R10 reset value g2 s5", r_data, 32'hA002_0005);
    chk("R9 rsp_valid after read", {31'h0, r_valid}, 32'h1);
    @(negedge clk);
    chk("R9 rsp_valid drops", {31'h0, rsp_valid}, 32'h0);
  endtask

  task automatic t_select();
    acc(1, 2, gk(3), 8'h10, 32'h1234_5678, 3'b000, 8'h00);
    chk("R9 write data zero", r_data, 32'h0);
    acc(0, 2, gk(3), 8'h10, 0, 3'b111, 8'hFF);
    chk("R1 readback other high bits", r_data, 32'h1234_5678);
    acc(0, 2, gk(4), 8'h10, 0);
    chk("R1 neighbour group untouched", r_data, 32'hA004_0004);
    acc(0, 2, gk(3), 8'h13, 0);
    chk("R1 low offset bits ignored", r_data, 32'h1234_5678);
  endtask

  task automatic t_widths();
    acc(1, 0, gk(5), 8'h08, 32'hFFFF_FFEE);
    acc(0, 2, gk(5), 8'h08, 0);
    chk("R5 byte write low 8", r_data, 32'hA005_00EE);
    acc(1, 1, gk(5), 8'h08, 32'hBEEF_1234);
    acc(0, 2, gk(5), 8'h08, 0);
    chk("R5 half write low 16", r_data, 32'hA005_1234);
    acc(0, 0, gk(5), 8'h08, 0);
    chk("R5 byte read", r_data, 32'h0000_0034);
    acc(0, 1, gk(5), 8'h08, 0);
    chk("R5 half read", r_data, 32'h0000_1234);
  endtask

  task automatic t_limits();
    acc(1, 2, gk(0), 8'h3C, 32'h55);
    chk("R2 write at limit no err", {31'h0, r_err}, 32'h0);
    acc(0, 2, gk(0), 8'h3C, 0);
    chk("R2 write at limit stored", r_data, 32'h55);
    acc(0, 2, gk(0), 8'h44, 0);
    chk("R2 read at read limit", r_data, 32'hA000_0011);
    chk("R2 read at limit no err", {31'h0, r_err}, 32'h0);
    acc(0, 2, gk(0), 8'h48, 0);
    chk("R2 read past limit err", {31'h0, r_err}, 32'h1);
    chk("R2 read past limit data", r_data, 32'h0);
    acc(0, 2, gk(1), 8'h10, 0);
    chk("R2 g1 read at 0x10", r_data, 32'hA001_0004);
    acc(1, 2, gk(1), 8'h10, 32'hDEAD_BEEF);
    chk("R2 g1 write 0x10 err", {31'h0, r_err}, 32'h1);
    acc(0, 2, gk(1), 8'h10, 0);
    chk("R2 g1 write dropped", r_data, 32'hA001_0004);
  endtask

  task automatic t_miss_holes();
    acc(0, 2, UNK, 8'h00, 0);
    chk("R3 unknown read err", {31'h0, r_err}, 32'h1);
    chk("R3 unknown read data", r_data, 32'h0);
    acc(1, 2, UNK, 8'h00, 32'h1);
    chk("R3 unknown write err", {31'h0, r_err}, 32'h1);
    acc(1, 2, HA, 8'h04, 32'hFFFF_FFFF);
    chk("R4 hole A write no err", {31'h0, r_err}, 32'h0);
    acc(0, 2, HB, 8'h00, 0);
    chk("R4 hole B read data", r_data, 32'h0);
    chk("R4 hole B read no err", {31'h0, r_err}, 32'h0);
  endtask

  task automatic t_attrs();
    acc(1, 2, gk(1), 8'h04, 32'h1111_2222);
    chk("R6 const write no err", {31'h0, r_err}, 32'h0);
    acc(0, 2, gk(1), 8'h04, 0);
    chk("R6 const keeps value", r_data, 32'hA001_0001);
    acc(0, 2, gk(0), 8'h08, 0);
    chk("R7 noaccess reads zero", r_data, 32'h0);
    acc(1, 2, gk(0), 8'h08, 32'h7777_7777);
    chk("R7 noaccess write no err", {31'h0, r_err}, 32'h0);
    acc(0, 2, gk(0), 8'h08, 0);
    chk("R7 noaccess still zero", r_data, 32'h0);
  endtask

  task automatic t_external();
    acc(0, 2, gk(0), 8'h0C, 0);
    chk("R8 read strobe", {30'h0, s_rd, s_wr}, 32'h2);
    chk("R8 strobe group/index", {22'h0, s_grp, s_idx}, {22'h0, 4'd0, 6'd3});
    chk("R8 read data from handler", r_data, 32'hCAFE_1234);
    acc(0, 0, gk(0), 8'h0C, 0);
    chk("R8 byte read from handler", r_data, 32'h0000_0034);
    acc(1, 2, gk(0), 8'h0C, 32'h0BAD_F00D);
    chk("R8 write strobe", {30'h0, s_rd, s_wr}, 32'h1);
    chk("R8 write strobe data", s_wdata, 32'h0BAD_F00D);
    @(negedge clk);
    chk("R8 strobe one cycle", {31'h0, ext_wr_stb}, 32'h0);
    acc(0, 2, gk(0), 8'h40, 0);
    chk("R8 in-read-range ext strobe", {26'h0, s_rd, s_idx[4:0]}, {26'h0, 1'b1, 5'd16});
    chk("R8 in-read-range no err", {31'h0, r_err}, 32'h0);
    acc(1, 2, gk(0), 8'h40, 32'h1);
    chk("R8 out-of-write-range no strobe", {30'h0, s_rd, s_wr}, 32'h0);
    chk("R2 out-of-write-range err", {31'h0, r_err}, 32'h1);
  endtask

  task automatic t_hard_reset();
    do_reset();
    acc(0, 2, gk(3), 8'h10, 0);
    chk("R10 slot restored g3", r_data, 32'hA003_0004);
    acc(0, 2, gk(5), 8'h08, 0);
    chk("R10 slot restored g5", r_data, 32'hA005_0002);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks + 1, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset_state();
    t_select();
    t_widths();
    t_limits();
    t_miss_holes();
    t_attrs();
    t_external();
    t_hard_reset();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule